// File: doc/BRIEF.md
# Reciprocal Period Counting Converter

This block measures a slow unknown frequency by counting reference clock cycles across a chosen number of complete periods of the unknown signal. A start strobe arms it. It then waits for the first rising edge of the unknown input, opens the window on that edge and closes it on the m-th rising edge after. The count it reports is close to m times the unknown period divided by the reference period.

Software recovers the frequency as the reference frequency times m, divided by the count; no divider is built in. The window edges are not aligned to the reference clock in a real system, so the count can be off by one. The error grows with the unknown frequency, so the block suits low frequencies. Choose m so that the count at the highest expected frequency fills the counter: m is about the maximum unknown frequency times 2^CNT_W, divided by the reference frequency. The unknown input must already be synchronized to the reference clock.

Top module: `recip_period_counter`

## Requirements
- R1: The reported count equals the number of reference cycles between the rising edge that opens the window and the m-th rising edge after it. For an input with a period of P cycles, that is m*P.
- R2: After start, the level of the unknown input is ignored until a rising edge occurs. An input that is already high at start, or stuck at either level, does not open the window.
- R3: periods_i is sampled on the start cycle and the value 0 is treated as 1. Changes to periods_i later in the measurement have no effect.
- R4: valid_o is high for exactly one cycle when a measurement ends. count_o, overflow_o and timeout_o then hold until the next start.
- R5: If the count would exceed 2^CNT_W-1, the measurement ends with valid_o, overflow_o=1 and count_o all ones. A count of exactly 2^CNT_W-1 is reported normally, with overflow_o=0.
- R6: If no rising edge opens the window within 2^CNT_W cycles after start, the measurement ends with valid_o, timeout_o=1 and count_o=0. overflow_o and timeout_o are never high together.
- R7: start_i is accepted at any time. It aborts a running measurement and begins a new one, and on the next cycle valid_o, overflow_o, timeout_o and count_o are all 0.
- R8: After reset the block is idle with count_o=0 and valid_o, overflow_o and timeout_o all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arms a new measurement |
| sig_i | input | 1 | Unknown signal, already synchronized to clk_i |
| periods_i | input | M_W | Number of unknown periods m in the window |
| count_o | output | CNT_W | Reference cycle count of the window |
| valid_o | output | 1 | One-cycle strobe at the end of a measurement |
| overflow_o | output | 1 | Count exceeded the counter range |
| timeout_o | output | 1 | No opening edge arrived in time |

## Verification
The hardest point to reach is the exact boundary between a full-scale count and an overflow. The window must last precisely 2^CNT_W-1 cycles in one run and one cycle longer in the next. The bench reduces CNT_W so that this range is short. It then drives single-period windows with periods of 2^CNT_W-1 and 2^CNT_W cycles, plus a multi-period window whose product is just past the limit. Restart in mid-window and a change to periods_i in mid-window are driven directly, so that a stale m or stale state would show in the count.

// File: rtl/recip_pkg.sv
package recip_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_COUNT = 2'd2
  } meas_state_e;
endpackage

// File: rtl/recip_edge_det.sv
module recip_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/recip_ref_cnt.sv
module recip_ref_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_max_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (en_i && (cnt_q != CntMax))  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = (cnt_q == CntMax);
endmodule

// File: rtl/recip_period_cnt.sv
module recip_period_cnt #(
  parameter int unsigned M_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           rise_en_i,
  input  logic [M_W-1:0] m_i,
  output logic           hit_o
);
  logic [M_W-1:0] edges_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        edges_q <= '0;
    else if (clr_i)     edges_q <= '0;
    else if (rise_en_i) edges_q <= edges_q + 1'b1;
  end

  // m_i is never zero here
  assign hit_o = rise_en_i && (edges_q == m_i - 1'b1);
endmodule

// File: rtl/recip_period_counter.sv
module recip_period_counter
  import recip_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned M_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sig_i,
  input  logic [M_W-1:0]   periods_i,
  output logic [CNT_W-1:0] count_o,
  output logic             valid_o,
  output logic             overflow_o,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] CntAll = {CNT_W{1'b1}};
  localparam logic [M_W-1:0]   MOne   = {{(M_W-1){1'b0}}, 1'b1};

  meas_state_e      state_q;
  logic [M_W-1:0]   m_q;
  logic [CNT_W-1:0] count_q;
  logic             valid_q, ovf_q, tmo_q;

  logic             rise;
  logic [CNT_W-1:0] ref_cnt;
  logic             ref_at_max;
  logic             close_hit;
  logic             open_win;

  assign open_win = (state_q == ST_ARM) && rise;

  recip_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sig_i),
    .rise_o (rise)
  );

  recip_ref_cnt #(.CNT_W(CNT_W)) u_ref (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_i | open_win),
    .en_i     (state_q != ST_IDLE),
    .cnt_o    (ref_cnt),
    .at_max_o (ref_at_max)
  );

  recip_period_cnt #(.M_W(M_W)) u_per (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_i | open_win),
    .rise_en_i ((state_q == ST_COUNT) && rise),
    .m_i       (m_q),
    .hit_o     (close_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      m_q     <= MOne;
      count_q <= '0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ARM;
      m_q     <= (periods_i == '0) ? MOne : periods_i;
      count_q <= '0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_ARM: begin
          if (rise) begin
            state_q <= ST_COUNT;
          end else if (ref_at_max) begin
            tmo_q   <= 1'b1;
            valid_q <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_COUNT: begin
          // saturation wins: a close at full scale would need one more code
          if (ref_at_max) begin
            ovf_q   <= 1'b1;
            count_q <= CntAll;
            valid_q <= 1'b1;
            state_q <= ST_IDLE;
          end else if (close_hit) begin
            count_q <= ref_cnt + 1'b1;
            valid_q <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign count_o    = count_q;
  assign valid_o    = valid_q;
  assign overflow_o = ovf_q;
  assign timeout_o  = tmo_q;
endmodule

// File: rtl/recip_chk.sv
module recip_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [CNT_W-1:0] count_o,
  input logic             valid_o,
  input logic             overflow_o,
  input logic             timeout_o
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R4

  AST_RESULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(count_o) || $rose(valid_o))); // R4

  AST_OVF_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (count_o == {CNT_W{1'b1}})); // R5

  AST_TMO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (count_o == '0)); // R6

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(overflow_o && timeout_o)); // R6

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!valid_o && !overflow_o && !timeout_o && count_o == '0)); // R7
endmodule

bind recip_period_counter recip_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .count_o    (count_o),
  .valid_o    (valid_o),
  .overflow_o (overflow_o),
  .timeout_o  (timeout_o)
);

// File: tb/tb_recip_period_counter.sv
module tb_recip_period_counter;
  localparam int CNT_W = 10;
  localparam int M_W   = 8;
  localparam int MAXC  = (1 << CNT_W) - 1;
  localparam int NVEC  = 8;
  // {m, period, expected count, expected overflow}
  localparam int VEC [NVEC][4] = '{
    '{1,   10,   10,   0},
    '{4,   7,    28,   0},
    '{0,   12,   12,   0},
    '{3,   2,    6,    0},
    '{255, 3,    765,  0},
    '{1,   1023, 1023, 0},
    '{1,   1024, 1023, 1},
    '{100, 11,   1023, 1}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             sig = 1'b0;
  logic [M_W-1:0]   periods = '0;
  logic [CNT_W-1:0] count;
  logic             valid, ovf, tmo;

  int applied = 0;
  int misses  = 0;
  int cyc     = 0;
  int gen_mode = 0;  // 0 low, 1 high, 2 periodic
  int gen_per  = 2;
  int ph       = 0;

  always #10 clk = ~clk;

  recip_period_counter #(.CNT_W(CNT_W), .M_W(M_W)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .sig_i      (sig),
    .periods_i  (periods),
    .count_o    (count),
    .valid_o    (valid),
    .overflow_o (ovf),
    .timeout_o  (tmo)
  );

  always @(negedge clk) begin
    if (gen_mode == 2) begin
      ph  = (ph + 1) % gen_per;
      sig <= (ph < gen_per / 2) || (ph == 0);
    end else begin
      sig <= (gen_mode == 1);
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      misses++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_start(input int m);
    @(negedge clk);
    periods = M_W'(m);
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
  endtask

  task automatic wait_valid(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (valid) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_result(input string req, input int exp_cnt, input int exp_ovf,
                              input int exp_tmo);
    bit seen;
    wait_valid(seen);
    chk({req, " valid seen"}, int'(seen), 1);
    chk({req, " count"}, int'(count), exp_cnt);
    chk({req, " overflow"}, int'(ovf), exp_ovf);
    chk({req, " timeout"}, int'(tmo), exp_tmo);
    @(negedge clk);
    chk("R4 valid one cycle", int'(valid), 0);
    repeat (3) @(negedge clk);
    chk("R4 count holds", int'(count), exp_cnt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 count", int'(count), 0);
    chk("R8 valid", int'(valid), 0);
    chk("R8 flags", int'(ovf | tmo), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      gen_mode = 2;
      gen_per  = VEC[v][1];
      do_start(VEC[v][0]);
      if (VEC[v][3] != 0) check_result("R5 overflow vector", VEC[v][2], 1, 0);
      else if (VEC[v][0] == 0) check_result("R3 m zero as one", VEC[v][2], 0, 0);
      else check_result("R1 count", VEC[v][2], 0, 0);
    end

    // R7 start clears a held result
    do_start(2);
    chk("R7 valid cleared", int'(valid), 0);
    chk("R7 count cleared", int'(count), 0);
    chk("R7 flags cleared", int'(ovf | tmo), 0);
    check_result("R1 after clear", 2 * gen_per, 0, 0);

    // R3 periods_i change mid-measurement ignored
    gen_per = 9;
    do_start(2);
    periods = 8'd9;
    check_result("R3 m latched", 18, 0, 0);

    // R7 restart mid-window with new m
    gen_per = 13;
    do_start(50);
    repeat (40) @(negedge clk);
    do_start(3);
    check_result("R7 restart", 39, 0, 0);

    // R6 stuck low times out
    gen_mode = 0;
    do_start(1);
    check_result("R6 stuck low timeout", 0, 0, 1);

    // R2 high at start is not an edge
    gen_mode = 1;
    repeat (2) @(negedge clk);
    do_start(1);
    check_result("R2 high level ignored", 0, 0, 1);

    summary();
    $finish;
  end
endmodule